// File: doc/BRIEF.md
# Half/Single Precision Floating-Point Converter

This block converts floating-point values between the 16-bit half format and the 32-bit single format, in either direction, chosen per operation by a direction input. Each operation is accepted on a cycle where the valid input is high and its result appears one clock later on a registered output, together with five exception flags. Widening (half to single) is exact for every non-NaN value, half denormals included. Narrowing (single to half) rounds to nearest, ties to even, and produces half denormals, zero or infinity as the magnitude calls for.

NaNs are not passed through by truncating the top significand bits. Instead, a fixed placement rule is used. The two most significant payload bits and the eight least significant payload bits keep their positions relative to the significand's top and bottom, and the bits in between are dropped (narrowing) or zero-filled (widening). When narrowing empties the payload, a fixed payload bit is set so that the result stays a NaN. A narrowed result occupies the low 16 bits of the 32-bit result.

Top module: `fp_half_single_conv`

## Requirements
- R1: When `in_valid` is high at a rising edge, the converted result and its flags appear on the outputs after that edge and `out_valid` is high for one cycle. After reset `out_valid` is 0. With `in_dir`=1 (narrow) the half result is in `out_data[15:0]` and `out_data[31:16]` is 0. With `in_dir`=0 (widen) the full 32-bit single result is driven.
- R2: Widening a finite half value, whether normal or denormal, gives the exactly equal single value and raises no flag. Half denormals are never flushed.
- R3: Widening a half NaN (exponent 31, significand m != 0) gives the single value {sign, 8'hFF, m[9:8] at bits 22:21, zeros at bits 20:8, m[7:0] at bits 7:0}.
- R4: Narrowing a single NaN (exponent 255, significand f != 0) gives the half value {sign, 5'h1F, f[22:21] at bits 9:8, f[7:0] at bits 7:0}. If those ten bits are all zero, bit 8 is set instead.
- R5: A signaling NaN input (top significand bit 0) raises invalid in either direction. A quiet NaN input raises no flag.
- R6: Narrowing a finite value rounds to nearest with ties to the even significand. The inexact flag is raised whenever any nonzero bit is discarded.
- R7: Narrowing produces half denormals and signed zero for small magnitudes. Underflow is raised when the unrounded magnitude is below 2^-14 and the result is inexact.
- R8: Narrowing a finite value whose rounded magnitude reaches 65536 or more gives a signed infinity (exponent 31, significand 0) and raises overflow and inexact.
- R9: The summary flag `out_any` is the OR of invalid, overflow, underflow and inexact, and is 0 when none is raised.
- R10: Infinities and signed zeros convert to the same signed class in either direction and raise no flag.
- R11: While `in_valid` is low, `out_data` and all flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| in_valid | input | 1 | Operation accepted this cycle |
| in_dir | input | 1 | 0: half to single, 1: single to half |
| in_data | input | 32 | Operand; a half operand sits in bits 15:0 |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_data | output | 32 | Result; a half result sits in bits 15:0 with bits 31:16 zero |
| out_invalid | output | 1 | Signaling NaN operand |
| out_overflow | output | 1 | Narrowed value too large, infinity returned |
| out_underflow | output | 1 | Tiny and inexact narrowed result |
| out_inexact | output | 1 | Rounding discarded nonzero bits |
| out_any | output | 1 | OR of the four exception flags |

## Verification
The assertions assume that `in_valid` and `in_dir` are never unknown after reset and that `in_data` is known whenever `in_valid` is high. For a half operand they also assume that only bits 15:0 carry meaning. The stimulus changes inputs only on falling clock edges, keeps `in_valid` low throughout reset, and places half operands with zero upper bits. The result checks are hand-derived bit patterns for rounding ties, denormal edges, overflow thresholds and NaN payload corners. These checks are compared by a scoreboard one cycle after each accepted operation.

// File: rtl/hpconv_pkg.sv
package hpconv_pkg;
  // format geometry
  localparam int H_EW = 5;
  localparam int H_MW = 10;
  localparam int S_EW = 8;
  localparam int S_MW = 23;
  localparam int H_W  = 1 + H_EW + H_MW;
  localparam int S_W  = 1 + S_EW + S_MW;
  localparam int H_BIAS = (1 << (H_EW - 1)) - 1;
  localparam int S_BIAS = (1 << (S_EW - 1)) - 1;
  localparam int BIAS_GAP = S_BIAS - H_BIAS;
  localparam int PAD = S_MW - H_MW;
  // NaN payload placement
  localparam int NAN_HI = 2;
  localparam int NAN_LO = 8;
  localparam int NAN_MID = S_MW - NAN_HI - NAN_LO;
  // narrowing thresholds (single biased exponent)
  localparam int MIN_NORM_E = BIAS_GAP + 1;
  localparam int OVF_E = S_BIAS + H_BIAS + 1;
  localparam int SH_MAX = 32;
  localparam int SH_W = 6;
  localparam int DEN_SH_REF = MIN_NORM_E + PAD;
  localparam int CAP_E = DEN_SH_REF - SH_MAX;
  localparam int WIDE_W = S_MW + 1 + SH_MAX;
  // lowest exponent reached by a widened half denormal
  localparam int DEN_BASE = S_BIAS - H_BIAS + 1 - H_MW;

  typedef struct packed {
    logic inv;
    logic ovf;
    logic unf;
    logic inx;
  } exc_t;
endpackage

// File: rtl/hpconv_widen.sv
module hpconv_widen
  import hpconv_pkg::*;
(
  input  logic [H_W-1:0] h_in,
  output logic [S_W-1:0] s_out,
  output exc_t           exc
);
  logic              sg;
  logic [H_EW-1:0]   ex;
  logic [H_MW-1:0]   mn;
  logic [3:0]        lead;
  logic [3:0]        shamt;
  logic [H_MW:0]     norm;
  logic [S_EW-1:0]   den_e;

  assign sg = h_in[H_W-1];
  assign ex = h_in[H_W-2 -: H_EW];
  assign mn = h_in[H_MW-1:0];

  // position of the leading one of a denormal significand
  always_comb begin
    lead = '0;
    for (int i = 0; i < H_MW; i++) begin
      if (mn[i]) lead = 4'(i);
    end
    shamt = 4'(H_MW) - lead;
    norm  = {1'b0, mn} << shamt;
    den_e = 8'(DEN_BASE) + {4'b0, lead};
  end

  always_comb begin
    exc = '0;
    if (ex == {H_EW{1'b1}}) begin
      if (mn == '0) begin
        s_out = {sg, {S_EW{1'b1}}, {S_MW{1'b0}}};
      end else begin
        s_out = {sg, {S_EW{1'b1}}, mn[H_MW-1 -: NAN_HI], {NAN_MID{1'b0}},
                 mn[NAN_LO-1:0]};
        exc.inv = ~mn[H_MW-1];
      end
    end else if (ex == '0) begin
      if (mn == '0) begin
        s_out = {sg, {(S_W-1){1'b0}}};
      end else begin
        s_out = {sg, den_e, norm[H_MW-1:0], {PAD{1'b0}}};
      end
    end else begin
      s_out = {sg, 8'({3'b0, ex} + 8'(BIAS_GAP)), mn, {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/hpconv_narrow.sv
module hpconv_narrow
  import hpconv_pkg::*;
(
  input  logic [S_W-1:0] s_in,
  output logic [H_W-1:0] h_out,
  output exc_t           exc
);
  logic              sg;
  logic [S_EW-1:0]   ex;
  logic [S_MW-1:0]   mf;
  logic [S_MW:0]     sig;
  logic [SH_W-1:0]   sh;
  logic [WIDE_W-1:0] wide;
  logic [S_MW:0]     kept;
  logic              grd;
  logic              stk;
  logic              rnd;
  logic              tiny;
  logic [H_W-2:0]    base;
  logic [H_W-2:0]    sum;
  logic [H_MW-1:0]   pay;

  assign sg  = s_in[S_W-1];
  assign ex  = s_in[S_W-2 -: S_EW];
  assign mf  = s_in[S_MW-1:0];
  assign sig = {|ex, mf};
  assign tiny = (ex < 8'(MIN_NORM_E));

  // alignment shift: fixed for normals, growing for denormal results
  always_comb begin
    if (!tiny) begin
      sh = SH_W'(PAD);
    end else if (ex < 8'(CAP_E)) begin
      sh = SH_W'(SH_MAX);
    end else begin
      sh = SH_W'(8'(DEN_SH_REF) - ex);
    end
    wide = {sig, {SH_MAX{1'b0}}} >> sh;
    kept = wide[WIDE_W-1 -: (S_MW + 1)];
    grd  = wide[SH_MAX-1];
    stk  = |wide[SH_MAX-2:0];
    rnd  = grd & (stk | kept[0]);
    if (tiny) begin
      base = {{H_EW{1'b0}}, kept[H_MW-1:0]};
    end else begin
      base = {H_EW'(ex - 8'(BIAS_GAP)), kept[H_MW-1:0]};
    end
    // a carry out of the significand moves into the exponent field
    sum = base + (H_W-1)'(rnd);
  end

  // NaN payload placement with forced nonzero payload
  always_comb begin
    pay = {mf[S_MW-1 -: NAN_HI], mf[NAN_LO-1:0]};
    if (pay == '0) pay[NAN_LO] = 1'b1;
  end

  always_comb begin
    exc = '0;
    if (ex == {S_EW{1'b1}}) begin
      if (mf == '0) begin
        h_out = {sg, {H_EW{1'b1}}, {H_MW{1'b0}}};
      end else begin
        h_out = {sg, {H_EW{1'b1}}, pay};
        exc.inv = ~mf[S_MW-1];
      end
    end else if (ex >= 8'(OVF_E)) begin
      h_out = {sg, {H_EW{1'b1}}, {H_MW{1'b0}}};
      exc.ovf = 1'b1;
      exc.inx = 1'b1;
    end else begin
      h_out   = {sg, sum};
      exc.inx = grd | stk;
      exc.ovf = (sum[H_W-2 -: H_EW] == {H_EW{1'b1}});
      exc.unf = tiny & (grd | stk);
    end
  end
endmodule

// File: rtl/fp_half_single_conv.sv
module fp_half_single_conv
  import hpconv_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_dir,
  input  logic [S_W-1:0] in_data,
  output logic           out_valid,
  output logic [S_W-1:0] out_data,
  output logic           out_invalid,
  output logic           out_overflow,
  output logic           out_underflow,
  output logic           out_inexact,
  output logic           out_any
);
  logic [S_W-1:0] w_res;
  exc_t           w_exc;
  logic [H_W-1:0] n_res;
  exc_t           n_exc;
  logic [S_W-1:0] nxt_data;
  exc_t           nxt_exc;
  logic           nxt_any;
  exc_t           exc_q;
  logic           any_q;

  hpconv_widen u_widen (
    .h_in  (in_data[H_W-1:0]),
    .s_out (w_res),
    .exc   (w_exc)
  );

  hpconv_narrow u_narrow (
    .s_in  (in_data),
    .h_out (n_res),
    .exc   (n_exc)
  );

  // next-state selection
  always_comb begin
    if (in_dir) begin
      nxt_data = {{(S_W-H_W){1'b0}}, n_res};
      nxt_exc  = n_exc;
    end else begin
      nxt_data = w_res;
      nxt_exc  = w_exc;
    end
    nxt_any = |nxt_exc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      exc_q    <= '0;
      any_q    <= 1'b0;
    end else if (in_valid) begin
      out_data <= nxt_data;
      exc_q    <= nxt_exc;
      any_q    <= nxt_any;
    end
  end

  assign out_invalid   = exc_q.inv;
  assign out_overflow  = exc_q.ovf;
  assign out_underflow = exc_q.unf;
  assign out_inexact   = exc_q.inx;
  assign out_any       = any_q;

  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dir) |=> (out_data[S_W-1:H_W] == '0)); // R1
  AST_WIDEN_NO_ARITH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_dir) |=> (!out_overflow && !out_underflow && !out_inexact)); // R2
  AST_NARROW_NAN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dir && (in_data[S_W-2 -: S_EW] == {S_EW{1'b1}}) && (in_data[S_MW-1:0] != '0))
    |=> ((out_data[H_W-2 -: H_EW] == {H_EW{1'b1}}) && (out_data[H_MW-1:0] != '0))); // R4
  AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> out_inexact); // R7
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> (out_inexact && (out_data[H_W-2:0] == {{H_EW{1'b1}}, {H_MW{1'b0}}}))); // R8
  AST_SUMMARY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_invalid || out_overflow || out_underflow || out_inexact)) |-> out_any); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_any) && $stable(out_inexact))); // R11
endmodule

// File: tb/tb_fp_half_single_conv.sv
`timescale 1ns/1ps
module tb_fp_half_single_conv;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_dir;
  logic [31:0] in_data;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_invalid;
  logic        out_overflow;
  logic        out_underflow;
  logic        out_inexact;
  logic        out_any;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [36:0] qv[$];
  string       qt[$];

  // flag vector order {any, invalid, overflow, underflow, inexact}
  localparam logic [4:0] F_NONE = 5'b00000;
  localparam logic [4:0] F_INV  = 5'b11000;
  localparam logic [4:0] F_OVI  = 5'b10101;
  localparam logic [4:0] F_INX  = 5'b10001;
  localparam logic [4:0] F_UNI  = 5'b10011;

  fp_half_single_conv dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dir(in_dir),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_invalid(out_invalid), .out_overflow(out_overflow),
    .out_underflow(out_underflow), .out_inexact(out_inexact),
    .out_any(out_any)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual flags=%b data=%h expected flags=%b data=%h",
               tag, act[36:32], act[31:0], exp[36:32], exp[31:0]);
    end
  endtask

  task automatic drive(input logic dir, input logic [31:0] din,
                       input logic [31:0] exp_d, input logic [4:0] exp_f,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_dir   = dir;
    in_data  = din;
    qv.push_back({exp_f, exp_d});
    qt.push_back(tag);
  endtask

  // monitor: compare each result against the oldest expected item
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (qv.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R1 unexpected out_valid actual=1 expected=0");
      end else begin
        check(qt.pop_front(),
              {out_any, out_invalid, out_overflow, out_underflow, out_inexact, out_data},
              qv.pop_front());
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_dir = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {4'b0, out_valid, out_data}, 37'd0);
    rst_n = 1'b1;
    // widening
    drive(0, 32'h3C00, 32'h3F800000, F_NONE, "R2 widen 1.0");
    drive(0, 32'hC000, 32'hC0000000, F_NONE, "R2 widen -2.0");
    drive(0, 32'h7BFF, 32'h477FE000, F_NONE, "R2 widen max half");
    drive(0, 32'h0001, 32'h33800000, F_NONE, "R2 widen min denormal");
    drive(0, 32'h0200, 32'h38000000, F_NONE, "R2 widen denormal 2^-15");
    drive(0, 32'h83FF, 32'hB87FC000, F_NONE, "R2 widen max negative denormal");
    drive(0, 32'h7C00, 32'h7F800000, F_NONE, "R10 widen +inf");
    drive(0, 32'h8000, 32'h80000000, F_NONE, "R10 widen -0");
    drive(0, 32'h7E55, 32'h7FC00055, F_NONE, "R3 R5 widen quiet NaN");
    drive(0, 32'hFD01, 32'hFFA00001, F_INV,  "R3 R5 widen signaling NaN");
    // narrowing: exact and rounding
    drive(1, 32'h3F800000, 32'h00003C00, F_NONE, "R1 R6 narrow 1.0");
    drive(1, 32'h477FE000, 32'h00007BFF, F_NONE, "R6 narrow max half exact");
    drive(1, 32'h3F801000, 32'h00003C00, F_INX,  "R6 tie to even down");
    drive(1, 32'h3F803000, 32'h00003C02, F_INX,  "R6 tie to even up");
    drive(1, 32'h3F801001, 32'h00003C01, F_INX,  "R6 above tie");
    drive(1, 32'h477FEFFF, 32'h00007BFF, F_INX,  "R6 just below overflow");
    // overflow
    drive(1, 32'h47800000, 32'h00007C00, F_OVI,  "R8 narrow 65536");
    drive(1, 32'hC7800000, 32'h0000FC00, F_OVI,  "R8 narrow -65536");
    drive(1, 32'h477FF000, 32'h00007C00, F_OVI,  "R8 rounding into overflow");
    // denormal outputs
    drive(1, 32'h33800000, 32'h00000001, F_NONE, "R7 exact min denormal");
    drive(1, 32'h38000000, 32'h00000200, F_NONE, "R7 exact denormal 2^-15");
    drive(1, 32'h33C00000, 32'h00000002, F_UNI,  "R7 denormal tie up");
    drive(1, 32'h33000000, 32'h00000000, F_UNI,  "R7 half min denormal ties to zero");
    drive(1, 32'h387FF000, 32'h00000400, F_UNI,  "R7 rounds up to min normal");
    drive(1, 32'h80000001, 32'h00008000, F_UNI,  "R7 single denormal to -0");
    drive(1, 32'h80000000, 32'h00008000, F_NONE, "R10 narrow -0");
    drive(1, 32'hFF800000, 32'h0000FC00, F_NONE, "R10 narrow -inf");
    // NaN payloads
    drive(1, 32'h7FC000AB, 32'h00007EAB, F_NONE, "R4 R5 R9 narrow quiet NaN");
    drive(1, 32'h7F801000, 32'h00007D00, F_INV,  "R4 R5 forced payload bit");
    drive(1, 32'hFFA00012, 32'h0000FD12, F_INV,  "R4 R9 narrow signaling NaN");
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 32'h3F800000;
    in_dir   = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 hold while idle",
          {out_any, out_invalid, out_overflow, out_underflow, out_inexact, out_data},
          {F_INV, 32'h0000FD12});
    check("R1 no valid while idle", {36'd0, out_valid}, 37'd0);
    check("R1 all results seen", 37'(qv.size()), 37'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule